// File: doc/BRIEF.md
# Linked-ring audio DMA channel

This block is one direction-switchable DMA channel for an audio serial port. It follows a ring of descriptors held in system memory. Each descriptor names a buffer period. The channel either reads the words of that period from memory and hands them to the transmit FIFO, or takes words from the receive FIFO and stores them into memory. When a period is done, the channel raises an interrupt and follows the link to the next descriptor.

Software drives the channel through one 64-bit order register. The upper field of that register carries a 32-byte-aligned address, and the low five bits carry commands and modes. Writing a start command makes the channel load the descriptor at that address. Writing a position request makes the channel copy its live descriptor state to that address, so software can read the exact transfer point. Writing a stop command parks the channel. Command bits clear themselves when the hardware has acted on them, and software polls for that.

Memory is reached through a single request/grant port whose read data is valid in the grant cycle. The FIFOs use valid/ready handshakes.

Top module: `pcm_ring_dma`

## Requirements
- R1: After reset the order register reads zero, `irq` is low, and `mem_req`, `tx_valid` and `rx_ready` are low.
- R2: Order register bit 3 is the start command. With the channel idle, the start bit reads back clear within a few cycles and the descriptor fetch begins at the address in bits 63:5, with bits 4:0 taken as zero. Bit 0 selects 64-bit addressing. When bit 0 is clear, the upper 32 bits of every address are forced to zero: the address from the order register, the descriptor's high link word and the descriptor's high memory word.
- R3: A descriptor is read as ten consecutive 32-bit words at byte offsets 0 to 36. Word 0 is the next-link low word (bit 0 marks the link valid, bits 31:5 hold the address). Word 1 is the memory address low. Word 2 is the device address. Word 3 is the length in 32-bit words. Words 4 and 5 are stride and repeat. Word 6 is the command. Word 7 is the status. Word 8 is the next-link high word. Word 9 is the memory address high.
- R4: When command bit 12 is set (playback), the channel reads `length` words from consecutive word addresses, starting at the memory address, and presents them on `tx_data` in order.
- R5: When command bit 12 is clear (capture), the channel accepts `length` words from `rx_data` and writes them to consecutive word addresses, starting at the memory address. It writes nothing beyond those words.
- R6: After the last word of a descriptor, the channel fetches the linked descriptor if link bit 0 is set, and otherwise goes idle. A descriptor of length 0 completes without moving any data.
- R7: Every completed descriptor sets `irq`. `irq` stays high until an `irq_clr` strobe. A completion in the same cycle as `irq_clr` leaves `irq` set.
- R8: Order register bit 2 is the position request. The channel writes ten words to the address in the order register, in the layout of R3. Word 1 and word 9 hold the live memory address of the next word to move, and word 3 holds the words still to move. Bit 2 clears after the last of these writes.
- R9: Order register bit 4 is the stop command. At the next word boundary the channel halts without moving the pending word, and bit 4 clears. A pending position request is served before the stop, and a later request still reports the stopped position.
- R10: While `mem_gnt` or the FIFO handshake is withheld, the channel keeps its request, address and data stable and loses no word. It also serves a position request while waiting on a FIFO.
- R11: Order register bit 1 (uncached access) is stored and read back, and has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ord_wr | input | 1 | Write strobe for the order register |
| ord_wdata | input | 64 | Order register write value |
| ord_rdata | output | 64 | Current order register value, with self-cleared bits |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| tx_valid | output | 1 | Playback word available |
| tx_ready | input | 1 | Transmit FIFO accepts the word |
| tx_data | output | 32 | Playback word |
| rx_valid | input | 1 | Capture word available |
| rx_ready | output | 1 | Channel accepts a capture word |
| rx_data | input | 32 | Capture word |
| irq | output | 1 | Descriptor-complete interrupt, level |
| irq_clr | input | 1 | Clears `irq` |

## Verification
Two functions can fall in the same cycle.

The first pair is the interrupt being cleared and a new completion setting it. The bench runs a one-word descriptor while `irq` is already high. It watches for the cycle in which the transmit handshake of that word is accepted, and raises `irq_clr` for exactly the following cycle, which is the cycle of completion. `irq` must still read high afterwards.

The second pair is a position request and a FIFO stall. The bench withholds `tx_ready` while a word is pending, so the request lands while the channel waits on the FIFO. The snapshot must show the address of the pending word, and that word must still be offered afterwards.

// File: rtl/pcm_ring_dma.sv
`timescale 1ns/1ps
module pcm_ring_dma #(
  parameter int DIR_BIT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ord_wr,
  input  logic [63:0] ord_wdata,
  output logic [63:0] ord_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [31:0] rx_data,
  output logic        irq,
  input  logic        irq_clr
);
  localparam logic [3:0] LAST = 4'd9;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WORD, S_MRD, S_PUSH, S_POP, S_MWR, S_SAVE} st_t;

  st_t         st, ret_st;
  logic [63:0] ord_q, cur_desc, save_base, maddr;
  logic [3:0]  widx;
  logic        a64;
  logic [31:0] nxt_lo, nxt_hi, dev_a, rem, stride, reps, cmd, stat, hold, snap;

  function automatic logic [63:0] fit(input logic [63:0] a, input logic wide);
    return wide ? a : {32'h0, a[31:0]};
  endfunction

  logic [63:0] ord_base, link, step, woff;
  logic hs, safe, take_ask, take_stop, take_start, save_end, done;

  assign ord_base   = fit({ord_q[63:5], 5'b0}, ord_q[0]);
  assign link       = fit({nxt_hi, nxt_lo[31:5], 5'b0}, a64);
  assign step       = fit(maddr + 64'd4, a64);
  assign woff       = {58'b0, widx, 2'b00};
  assign hs         = (st == S_PUSH && tx_ready) || (st == S_POP && rx_valid);
  assign safe       = (st == S_IDLE || st == S_WORD || st == S_PUSH || st == S_POP) && !hs;
  assign take_ask   = safe && ord_q[2];
  assign take_stop  = safe && !ord_q[2] && ord_q[4];
  assign take_start = st == S_IDLE && !ord_q[2] && !ord_q[4] && ord_q[3];
  assign save_end   = st == S_SAVE && mem_gnt && widx == LAST;
  assign done       = st == S_WORD && !take_ask && !take_stop && rem == 32'd0;

  always_comb begin
    case (widx)
      4'd0:    snap = nxt_lo;
      4'd1:    snap = maddr[31:0];
      4'd2:    snap = dev_a;
      4'd3:    snap = rem;
      4'd4:    snap = stride;
      4'd5:    snap = reps;
      4'd6:    snap = cmd;
      4'd7:    snap = stat;
      4'd8:    snap = nxt_hi;
      4'd9:    snap = maddr[63:32];
      default: snap = 32'h0;
    endcase
  end

  assign mem_req   = st == S_FETCH || st == S_MRD || st == S_MWR || st == S_SAVE;
  assign mem_we    = st == S_MWR || st == S_SAVE;
  assign mem_addr  = (st == S_FETCH) ? cur_desc + woff :
                     (st == S_SAVE)  ? save_base + woff : maddr;
  assign mem_wdata = (st == S_SAVE) ? snap : hold;
  assign tx_valid  = st == S_PUSH;
  assign tx_data   = hold;
  assign rx_ready  = st == S_POP;
  assign ord_rdata = ord_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ord_q <= '0;
    end else if (ord_wr) begin
      ord_q <= ord_wdata;
    end else begin
      if (take_start) ord_q[3] <= 1'b0;
      if (save_end)   ord_q[2] <= 1'b0;
      if (take_stop)  ord_q[4] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (done)    irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ret_st    <= S_IDLE;
      widx      <= '0;
      a64       <= 1'b0;
      cur_desc  <= '0;
      save_base <= '0;
      maddr     <= '0;
      nxt_lo    <= '0;
      nxt_hi    <= '0;
      dev_a     <= '0;
      rem       <= '0;
      stride    <= '0;
      reps      <= '0;
      cmd       <= '0;
      stat      <= '0;
      hold      <= '0;
    end else if (take_ask) begin
      save_base <= ord_base;
      ret_st    <= st;
      widx      <= '0;
      st        <= S_SAVE;
    end else if (take_stop) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (take_start) begin
          cur_desc <= ord_base;
          a64      <= ord_q[0];
          widx     <= '0;
          st       <= S_FETCH;
        end
        S_FETCH: if (mem_gnt) begin
          case (widx)
            4'd0: nxt_lo       <= mem_rdata;
            4'd1: maddr[31:0]  <= mem_rdata;
            4'd2: dev_a        <= mem_rdata;
            4'd3: rem          <= mem_rdata;
            4'd4: stride       <= mem_rdata;
            4'd5: reps         <= mem_rdata;
            4'd6: cmd          <= mem_rdata;
            4'd7: stat         <= mem_rdata;
            4'd8: nxt_hi       <= mem_rdata;
            4'd9: maddr[63:32] <= a64 ? mem_rdata : 32'h0;
            default: ;
          endcase
          if (widx == LAST) begin
            widx <= '0;
            st   <= S_WORD;
          end else begin
            widx <= widx + 4'd1;
          end
        end
        S_WORD: begin
          if (rem == 32'd0) begin
            if (nxt_lo[0]) begin
              cur_desc <= link;
              widx     <= '0;
              st       <= S_FETCH;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            st <= cmd[DIR_BIT] ? S_MRD : S_POP;
          end
        end
        S_MRD: if (mem_gnt) begin
          hold <= mem_rdata;
          st   <= S_PUSH;
        end
        S_PUSH: if (tx_ready) begin
          maddr <= step;
          rem   <= rem - 32'd1;
          st    <= S_WORD;
        end
        S_POP: if (rx_valid) begin
          hold <= rx_data;
          st   <= S_MWR;
        end
        S_MWR: if (mem_gnt) begin
          maddr <= step;
          rem   <= rem - 32'd1;
          st    <= S_WORD;
        end
        S_SAVE: if (mem_gnt) begin
          if (widx == LAST) begin
            widx <= '0;
            st   <= ret_st;
          end else begin
            widx <= widx + 4'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcm_ring_dma_chk.sv
`timescale 1ns/1ps
module pcm_ring_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ord_wr,
  input logic [63:0] ord_rdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_gnt,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        rx_ready,
  input logic        irq,
  input logic        irq_clr
);
  assert_mem_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_tx_word_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> $stable(tx_data));

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  assert_one_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, rx_ready, mem_req}));

  assert_ask_clear_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ord_rdata[2]) && !$past(ord_wr) |-> $past(mem_req && mem_we && mem_gnt));

  assert_start_clear_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ord_rdata[3]) && !$past(ord_wr) |-> mem_req && !mem_we);
endmodule

bind pcm_ring_dma pcm_ring_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ord_wr(ord_wr), .ord_rdata(ord_rdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_gnt(mem_gnt), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_ready(rx_ready), .irq(irq), .irq_clr(irq_clr)
);

// File: tb/pcm_ring_dma_tb.sv
`timescale 1ns/1ps
module pcm_ring_dma_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ord_wr;
  logic [63:0] ord_wdata, ord_rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, rx_valid, rx_ready, irq, irq_clr;
  logic [31:0] tx_data, rx_data;

  pcm_ring_dma u_dut (
    .clk(clk), .rst_n(rst_n), .ord_wr(ord_wr), .ord_wdata(ord_wdata), .ord_rdata(ord_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq(irq), .irq_clr(irq_clr)
  );

  int checks = 0, errors = 0;
  int cyc = 0, rec_n = 0, tx_lim = 0, rx_idx = 0, rx_total = 0;
  logic [31:0] rec [0:63];
  logic [31:0] mem [0:1023];

  assign mem_rdata = (mem_addr[63:12] == 52'd0) ? mem[mem_addr[11:2]] : 32'hBAD0BAD0;
  always @(posedge clk)
    if (mem_req && mem_we && mem_gnt && mem_addr[63:12] == 52'd0)
      mem[mem_addr[11:2]] <= mem_wdata;

  initial begin
    mem_gnt = 1'b0; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_gnt  = (cyc % 3) != 0;
      tx_ready = (rec_n < tx_lim) && (cyc % 5 != 2);
      if (tx_valid && tx_ready) begin
        if (rec_n < 64) rec[rec_n] = tx_data;
        rec_n++;
      end
      rx_valid = (rx_idx < rx_total) && (cyc % 4 != 1);
      rx_data  = 32'hC0DE0000 + 32'(rx_idx);
      if (rx_valid && rx_ready) rx_idx++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ord_write(input logic [63:0] v);
    @(negedge clk); ord_wr = 1'b1; ord_wdata = v;
    @(negedge clk); ord_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic wait_bit_clear(input int b);
    for (int i = 0; i < 400; i++) begin
      if (!ord_rdata[b]) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_rec(input int n);
    for (int i = 0; i < 3000; i++) begin
      if (rec_n >= n) break;
      @(negedge clk);
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic put_desc(input int base, input logic [31:0] nlo, input logic [31:0] mlo,
                          input logic [31:0] dev, input logic [31:0] len, input logic [31:0] cmd,
                          input logic [31:0] nhi, input logic [31:0] mhi);
    int w;
    w = base >> 2;
    mem[w+0] = nlo; mem[w+1] = mlo; mem[w+2] = dev; mem[w+3] = len;
    mem[w+4] = 0;   mem[w+5] = 1;   mem[w+6] = cmd; mem[w+7] = 0;
    mem[w+8] = nhi; mem[w+9] = mhi;
    for (int k = 10; k < 16; k++) mem[w+k] = 0;
  endtask

  task automatic t_reset();
    chk("R1 order register", ord_rdata, 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 idle outputs", 64'({mem_req, tx_valid, rx_ready}), 64'h0);
  endtask

  task automatic t_play();
    int base;
    base = rec_n;
    tx_lim = 100;
    for (int i = 0; i < 4; i++) mem[(32'h400 >> 2) + i] = 32'hA0000000 + 32'(i);
    for (int i = 0; i < 3; i++) mem[(32'h480 >> 2) + i] = 32'hB0000000 + 32'(i);
    put_desc(32'h100, 32'h141, 32'h400, 32'hBEEF0010, 4, 32'h1001, 0, 0);
    put_desc(32'h140, 32'h0,   32'h480, 32'hBEEF0010, 3, 32'h1001, 0, 0);
    ord_write(64'h100 | 64'h0B);
    wait_bit_clear(3);
    chk("R2 start bit cleared", 64'(ord_rdata[3]), 64'h0);
    chk("R11 mode bits and address kept", ord_rdata, 64'h103);
    wait_rec(base + 7);
    chk("R6 words over two chained descriptors", 64'(rec_n - base), 64'd7);
    for (int i = 0; i < 4; i++)
      chk("R3 R4 R10 playback first period", 64'(rec[base+i]), 64'(32'hA0000000 + 32'(i)));
    for (int i = 0; i < 3; i++)
      chk("R4 R6 playback linked period", 64'(rec[base+4+i]), 64'(32'hB0000000 + 32'(i)));
    chk("R7 irq after completion", 64'(irq), 64'h1);
    pulse_clr();
    chk("R7 irq cleared by strobe", 64'(irq), 64'h0);
  endtask

  task automatic t_capture();
    for (int i = 0; i < 6; i++) mem[(32'h700 >> 2) + i] = 32'h0;
    put_desc(32'h180, 32'h0, 32'h700, 32'hBEEF000C, 5, 32'h0001, 0, 0);
    rx_idx = 0; rx_total = 5;
    ord_write(64'h180 | 64'h09);
    for (int i = 0; i < 3000; i++) begin
      if (rx_idx >= 5) break;
      @(negedge clk);
    end
    repeat (30) @(negedge clk);
    for (int i = 0; i < 5; i++)
      chk("R5 capture word stored", 64'(mem[(32'h700 >> 2) + i]), 64'(32'hC0DE0000 + 32'(i)));
    chk("R5 nothing past period", 64'(mem[(32'h700 >> 2) + 5]), 64'h0);
    chk("R7 irq after capture", 64'(irq), 64'h1);
    pulse_clr();
  endtask

  task automatic t_a64off();
    int base;
    base = rec_n;
    mem[(32'h580 >> 2) + 0] = 32'hE0E0E0E0;
    mem[(32'h580 >> 2) + 1] = 32'hE1E1E1E1;
    put_desc(32'h200, 32'h0, 32'h580, 0, 2, 32'h1001, 32'h77, 32'h55);
    ord_write({32'h9, 32'h200} | 64'h08);
    wait_rec(base + 2);
    chk("R2 32-bit mode word 0", 64'(rec[base]), 64'hE0E0E0E0);
    chk("R2 32-bit mode word 1", 64'(rec[base+1]), 64'hE1E1E1E1);
    pulse_clr();
  endtask

  task automatic t_ask();
    int base;
    base = rec_n;
    put_desc(32'h140, 32'h101, 32'h480, 32'hBEEF0010, 3, 32'h1001, 0, 0);
    tx_lim = base + 2;
    ord_write(64'h100 | 64'h09);
    for (int i = 0; i < 2000; i++) begin
      if (rec_n >= base + 2) break;
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
    ord_write(64'h600 | 64'h05);
    wait_bit_clear(2);
    chk("R8 request bit cleared", 64'(ord_rdata[2]), 64'h0);
    chk("R8 snapshot link word", 64'(mem[32'h180 + 0]), 64'h141);
    chk("R8 snapshot live address", 64'(mem[32'h180 + 1]), 64'h408);
    chk("R8 snapshot device word", 64'(mem[32'h180 + 2]), 64'hBEEF0010);
    chk("R8 snapshot remaining", 64'(mem[32'h180 + 3]), 64'h2);
    chk("R8 snapshot command", 64'(mem[32'h180 + 6]), 64'h1001);
    chk("R8 snapshot address high", 64'(mem[32'h180 + 9]), 64'h0);
    chk("R10 pending word still offered", 64'(tx_valid), 64'h1);
    chk("R10 pending word data", 64'(tx_data), 64'hA0000002);
    ord_write(64'h600 | 64'h11);
    wait_bit_clear(4);
    chk("R9 stop bit cleared", 64'(ord_rdata[4]), 64'h0);
    tx_lim = 100;
    repeat (40) @(negedge clk);
    chk("R9 no word after stop", 64'(rec_n - base), 64'd2);
    chk("R9 channel parked", 64'({tx_valid, mem_req}), 64'h0);
    ord_write(64'h640 | 64'h05);
    wait_bit_clear(2);
    chk("R9 stopped position address", 64'(mem[32'h190 + 1]), 64'h408);
    chk("R9 stopped position remaining", 64'(mem[32'h190 + 3]), 64'h2);
  endtask

  task automatic t_zero();
    int base;
    base = rec_n;
    pulse_clr();
    put_desc(32'h1C0, 32'h0, 32'h400, 0, 0, 32'h1001, 0, 0);
    ord_write(64'h1C0 | 64'h09);
    repeat (60) @(negedge clk);
    chk("R6 zero length completes", 64'(irq), 64'h1);
    chk("R6 zero length moves nothing", 64'(rec_n - base), 64'd0);
  endtask

  task automatic t_collide();
    int base;
    base = rec_n;
    chk("R7 irq high before collision", 64'(irq), 64'h1);
    put_desc(32'h1C0, 32'h0, 32'h400, 0, 1, 32'h1001, 0, 0);
    ord_write(64'h1C0 | 64'h09);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (rec_n >= base + 1) break;
    end
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R7 completion beats clear strobe", 64'(irq), 64'h1);
    pulse_clr();
    chk("R7 later clear works", 64'(irq), 64'h0);
  endtask

  initial begin
    ord_wr = 1'b0; ord_wdata = '0; irq_clr = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_play();
    t_capture();
    t_a64off();
    t_ask();
    t_zero();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule